// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Idle Flag

This block recovers characters from one asynchronous serial line. An external oversampling tick, `OVS` pulses per bit period, times the search for a start bit, the check that it is real, and the sampling of every later bit near its centre. The frame format is set by static configuration pins:
- 7 or 8 data bits, sent least or most significant bit first.
- An optional parity bit, or a multiprocessor marker bit that separates address words from data words.
- One or two stop bits.

Each finished word is offered on a valid/ready output port. `m_valid` rises when the first stop bit is sampled and stays high until a cycle with `m_ready` high accepts the word. The receiver cannot be stalled by back-pressure. If a new frame completes while the old word is still unread, the new word replaces it. If completion and acceptance fall in the same cycle, the new word wins and `m_valid` stays high. The parity-error, framing-error and bus-idle flags are plain status pins.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `m_valid`, `par_err`, `frm_err` and `m_marker` are 0 and `bus_idle` is 1.
- R2: A low level is taken as a start bit only if the line is still low half a bit period after the receiver sees it fall. A shorter pulse yields no word and leaves `bus_idle` at 1.
- R3: In least-significant-first order, the first data bit received lands in `m_data[0]`. With `cfg_data8`=0 only 7 data bits are received and `m_data[7]` reads 0.
- R4: With `cfg_msb_first`=1, the first data bit received lands in the top data position: bit 7 for 8-bit words, bit 6 for 7-bit words.
- R5: With `cfg_par_en`=1 and `cfg_mp`=0, one parity bit follows the data. For `cfg_par_odd`=0 the expected parity bit is the XOR of the data bits; for `cfg_par_odd`=1 it is the inverse of that XOR. `par_err` is 1 for a frame whose parity bit differs from the expected value, and 0 otherwise.
- R6: With `cfg_mp`=1, the bit after the data is presented on `m_marker` (1 = address word) and `par_err` is 0. `cfg_mp` takes precedence over `cfg_par_en`. With `cfg_mp`=0, `m_marker` is 0.
- R7: `frm_err` is 1 if the first stop bit is sampled low, or if `cfg_stop2`=1 and the second stop bit is sampled low.
- R8: `m_valid` rises while the first stop bit is still on the line, not after the second stop bit.
- R9: `bus_idle` falls when a start bit is confirmed. It rises again only after the last configured stop bit has ended, within one bit period of that end, and it stays low when a new start bit follows straight on.
- R10: An accepting cycle (`m_valid` and `m_ready` high) with no new word clears `m_valid`. A word completing in the same cycle keeps `m_valid` high with the new data. An unread word is replaced by a newer frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversampling tick, OVS per bit period |
| cfg_data8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_mp | input | 1 | Multiprocessor marker bit present |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_msb_first | input | 1 | Most significant data bit first |
| m_valid | output | 1 | Received word available |
| m_ready | input | 1 | Consumer accepts the word |
| m_data | output | DW | Received word |
| m_marker | output | 1 | Address/data marker of the word |
| par_err | output | 1 | Parity mismatch in the word |
| frm_err | output | 1 | Stop bit sampled low in the word |
| bus_idle | output | 1 | Line idle after the last stop bit |

## Verification
A new word completing and the pending word being accepted can fall in the same clock cycle. To provoke this, the bench first measures, at the ports alone, how many cycles pass from the start edge of a frame to the rise of `m_valid`. It then sends a second frame with an older word still pending, and raises `m_ready` for exactly that cycle. The result is judged by `m_valid` staying high and `m_data` holding the second word.

// File: rtl/arx_pkg.sv
package arx_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP1,
    ST_STOP2,
    ST_TAIL
  } arx_state_e;
endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/arx_assembler.sv
module arx_assembler #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic          bit_i,
  input  logic [IW-1:0] idx_i,
  input  logic          msb_first_i,
  input  logic          short_i,
  output logic [DW-1:0] word_o,
  output logic          xor_o
);
  logic [IW-1:0] top_pos, pos;

  // Highest occupied position depends on word length.
  assign top_pos = short_i ? IW'(DW-2) : IW'(DW-1);
  assign pos     = msb_first_i ? (top_pos - idx_i) : idx_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      word_o <= '0;
    else if (clr_i)  word_o <= '0;
    else if (load_i) word_o[pos] <= bit_i;

  assign xor_o = ^word_o;

  // R4: a short word never writes the top position.
  assert_short_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && short_i) |=> !word_o[DW-1]);
endmodule

// File: rtl/arx_hold.sv
module arx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] word_i,
  input  logic          marker_i,
  input  logic          perr_i,
  input  logic          ferr_i,
  input  logic          stop2_bad_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          marker_o,
  output logic          perr_o,
  output logic          ferr_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      valid_o  <= 1'b0;
      data_o   <= '0;
      marker_o <= 1'b0;
      perr_o   <= 1'b0;
      ferr_o   <= 1'b0;
    end else if (load_i) begin
      // New word wins over a same-cycle acceptance.
      valid_o  <= 1'b1;
      data_o   <= word_i;
      marker_o <= marker_i;
      perr_o   <= perr_i;
      ferr_o   <= ferr_i;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (stop2_bad_i)        ferr_o  <= 1'b1;
    end

  assert_load_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> valid_o);
  assert_take_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && !load_i) |=> !valid_o);
  assert_word_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !load_i) |=> $stable(data_o));
  assert_second_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop2_bad_i |=> ferr_o);
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import arx_pkg::*;
#(
  parameter int DW       = 8,
  parameter int OVS      = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          os_tick,
  input  logic          cfg_data8,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_mp,
  input  logic          cfg_stop2,
  input  logic          cfg_msb_first,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_marker,
  output logic          par_err,
  output logic          frm_err,
  output logic          bus_idle
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  arx_state_e    st;
  logic          rx_s;
  logic [CW-1:0] os_cnt;
  logic [IW-1:0] idx;
  logic [IW-1:0] last_idx;
  logic          extra_q;
  logic          use_extra;
  logic          smp;
  logic          start_ok;
  logic          done;
  logic          stop2_bad;
  logic [DW-1:0] asm_word;
  logic          asm_xor;
  logic          par_bad;

  arx_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_line), .q_o(rx_s));

  assign last_idx  = cfg_data8 ? IW'(DW-1) : IW'(DW-2);
  assign use_extra = cfg_par_en | cfg_mp;
  assign smp       = os_tick && (os_cnt == LAST);
  assign start_ok  = os_tick && (st == ST_START) && (os_cnt == MID) && !rx_s;
  assign done      = smp && (st == ST_STOP1);
  assign stop2_bad = smp && (st == ST_STOP2) && !rx_s;
  assign par_bad   = extra_q ^ asm_xor ^ cfg_par_odd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_HUNT;
      os_cnt   <= '0;
      idx      <= '0;
      extra_q  <= 1'b0;
      bus_idle <= 1'b1;
    end else if (os_tick) begin
      case (st)
        ST_HUNT:
          if (!rx_s) begin
            st     <= ST_START;
            os_cnt <= '0;
          end
        ST_START:
          if (os_cnt == MID) begin
            os_cnt <= '0;
            if (!rx_s) begin
              st       <= ST_DATA;
              idx      <= '0;
              bus_idle <= 1'b0;
            end else begin
              // Pulse too short: line is back at mark level.
              st       <= ST_HUNT;
              bus_idle <= 1'b1;
            end
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        ST_TAIL:
          if (!rx_s) begin
            st     <= ST_START;
            os_cnt <= '0;
          end else if (os_cnt == MID) begin
            st       <= ST_HUNT;
            os_cnt   <= '0;
            bus_idle <= 1'b1;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        default:
          if (os_cnt == LAST) begin
            os_cnt <= '0;
            case (st)
              ST_DATA: begin
                idx <= idx + 1'b1;
                if (idx == last_idx) st <= use_extra ? ST_EXTRA : ST_STOP1;
              end
              ST_EXTRA: begin
                extra_q <= rx_s;
                st      <= ST_STOP1;
              end
              ST_STOP1: st <= cfg_stop2 ? ST_STOP2 : ST_TAIL;
              default:  st <= ST_TAIL;
            endcase
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
      endcase
    end

  arx_assembler #(.DW(DW)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .clr_i(start_ok),
    .load_i(smp && (st == ST_DATA)),
    .bit_i(rx_s),
    .idx_i(idx),
    .msb_first_i(cfg_msb_first),
    .short_i(!cfg_data8),
    .word_o(asm_word),
    .xor_o(asm_xor));

  arx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load_i(done),
    .word_i(asm_word),
    .marker_i(cfg_mp & extra_q),
    .perr_i(cfg_par_en & ~cfg_mp & par_bad),
    .ferr_i(!rx_s),
    .stop2_bad_i(stop2_bad),
    .ready_i(m_ready),
    .valid_o(m_valid),
    .data_o(m_data),
    .marker_o(m_marker),
    .perr_o(par_err),
    .ferr_o(frm_err));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_START && st == ST_DATA) |-> !$past(rx_s));
  assert_short_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_data8) |=> !m_data[DW-1]);
  assert_mp_no_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_mp) |=> !par_err);
  assert_busy_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA || st == ST_EXTRA || st == ST_STOP1 || st == ST_STOP2) |-> !bus_idle);
  assert_idle_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_idle) |-> ($past(st) == ST_TAIL || $past(st) == ST_START));
endmodule

// File: tb/test_serial_frame_rx.sv
`timescale 1ns/1ps
module test_serial_frame_rx;
  localparam int OVS = 16;
  localparam int DW  = 8;

  logic clk = 1'b0, rst_n = 1'b0, rx_line = 1'b1, os_tick = 1'b1;
  logic cfg_data8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic cfg_mp = 1'b0, cfg_stop2 = 1'b0, cfg_msb_first = 1'b0;
  logic m_valid, m_ready = 1'b0, m_marker, par_err, frm_err, bus_idle;
  logic [DW-1:0] m_data;

  always #4 clk = ~clk;

  serial_frame_rx #(.DW(DW), .OVS(OVS)) i_serial_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .cfg_data8(cfg_data8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_mp(cfg_mp), .cfg_stop2(cfg_stop2), .cfg_msb_first(cfg_msb_first),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_marker(m_marker),
    .par_err(par_err), .frm_err(frm_err), .bus_idle(bus_idle));

  int n_checks = 0, n_err = 0;
  int rdy_at = -1, t_valid, t_idle;
  bit idle_early;

  typedef struct packed {
    logic [7:0] d;
    logic d8, pen, podd, mp, mk, st2, msb, badp, bads1, bads2;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'hA5, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{8'h3C, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{8'h5A, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{8'h13, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0},
    '{8'h6E, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0},
    '{8'h41, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0},
    '{8'h99, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0},
    '{8'h2B, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{8'hFF, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0},
    '{8'h80, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{8'h0F, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_data8 = v.d8; cfg_par_en = v.pen; cfg_par_odd = v.podd;
    cfg_mp = v.mp; cfg_stop2 = v.st2; cfg_msb_first = v.msb;
  endtask

  // Called at a falling clock edge; drives one frame plus idle bits.
  task automatic send(input vec_t v, input int tail_bits);
    logic bits [16];
    int nb, n, c;
    logic p, lvl;
    bit was_busy;
    nb = v.d8 ? 8 : 7;
    p  = (^(v.d & (v.d8 ? 8'hFF : 8'h7F))) ^ v.podd ^ v.badp;
    bits[0] = 1'b0; n = 1;
    for (int i = 0; i < nb; i++) begin
      bits[n] = v.msb ? v.d[nb-1-i] : v.d[i];
      n++;
    end
    if (v.mp) begin bits[n] = v.mk; n++; end
    else if (v.pen) begin bits[n] = p; n++; end
    bits[n] = ~v.bads1; n++;
    if (v.st2) begin bits[n] = ~v.bads2; n++; end
    c = 0; t_valid = -1; t_idle = -1; idle_early = 0; was_busy = 0;
    for (int j = 0; j < n + tail_bits; j++) begin
      lvl = (j < n) ? bits[j] : 1'b1;
      for (int k = 0; k < OVS; k++) begin
        rx_line = lvl;
        m_ready = (c == rdy_at);
        @(posedge clk); c++; @(negedge clk);
        if (t_valid < 0 && m_valid) t_valid = c;
        if (!bus_idle) was_busy = 1;
        else if (was_busy && t_idle < 0) t_idle = c;
        if (c < OVS && bus_idle) idle_early = 1;
      end
    end
    m_ready = 1'b0;
  endtask

  task automatic consume();
    m_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    m_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    vec_t v;
    logic [7:0] ed;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(m_valid == 1'b0, "R1 valid", m_valid, 0);
    check(bus_idle == 1'b1, "R1 idle", bus_idle, 1);
    check({par_err, frm_err, m_marker} == 3'b000, "R1 flags", {par_err, frm_err, m_marker}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      set_cfg(v);
      send(v, 3);
      ed = v.d & (v.d8 ? 8'hFF : 8'h7F);
      check(m_valid == 1'b1, "R8 word offered", m_valid, 1);
      check(m_data == ed, v.msb ? "R4 msb order" : "R3 lsb order", m_data, ed);
      check(m_marker == (v.mp & v.mk), "R6 marker", m_marker, v.mp & v.mk);
      check(par_err == (v.pen & ~v.mp & v.badp), "R5 parity", par_err, v.pen & ~v.mp & v.badp);
      check(frm_err == (v.bads1 | (v.st2 & v.bads2)), "R7 framing", frm_err, v.bads1 | (v.st2 & v.bads2));
      check(bus_idle == 1'b1, "R9 idle after frame", bus_idle, 1);
      consume();
      check(m_valid == 1'b0, "R10 accept clears", m_valid, 0);
    end

    // R8/R9 timing with two stop bits: stop1 is bit 9, frame is 11 bits
    v = '{8'h55, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0};
    set_cfg(v);
    send(v, 3);
    check(t_valid >= 9*OVS && t_valid < 10*OVS, "R8 ready at first stop", t_valid, 9*OVS);
    check(t_idle >= 11*OVS && t_idle <= 12*OVS, "R9 idle after second stop", t_idle, 11*OVS);
    check(idle_early == 1, "R9 idle before start", idle_early, 1);
    consume();

    // R9 with one stop bit: frame is 10 bits
    v.st2 = 1'b0;
    set_cfg(v);
    send(v, 3);
    check(t_idle >= 10*OVS && t_idle <= 11*OVS, "R9 idle after single stop", t_idle, 10*OVS);
    consume();

    // R9/R10 back-to-back frames: no idle gap, unread word replaced
    v = '{8'h11, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0};
    set_cfg(v);
    send(v, 0);
    v.d = 8'h22;
    send(v, 3);
    check(idle_early == 0, "R9 no idle between frames", idle_early, 0);
    check(m_data == 8'h22, "R10 newer word replaces", m_data, 8'h22);
    consume();

    // R2 short low pulse is rejected
    begin
      bit idle_low;
      idle_low = 0;
      rx_line = 1'b0;
      repeat (4) begin @(posedge clk); @(negedge clk); if (!bus_idle) idle_low = 1; end
      rx_line = 1'b1;
      repeat (40) begin @(posedge clk); @(negedge clk); if (!bus_idle) idle_low = 1; end
      check(m_valid == 1'b0, "R2 glitch gives no word", m_valid, 0);
      check(idle_low == 0, "R2 glitch keeps idle", idle_low, 0);
    end

    // R10 completion and acceptance in the same cycle
    begin
      int lat;
      v = '{8'h5C, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
      set_cfg(v);
      send(v, 3);
      lat = t_valid;
      check(lat > 0, "R10 latency measured", lat, 1);
      v.d = 8'hC3;
      rdy_at = lat - 1;
      send(v, 3);
      rdy_at = -1;
      check(m_valid == 1'b1, "R10 new word wins collision", m_valid, 1);
      check(m_data == 8'hC3, "R10 collision data", m_data, 8'hC3);
      consume();
      check(m_valid == 1'b0, "R10 accept after collision", m_valid, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule